// File: doc/BRIEF.md
# Lowest-Index Claim/Complete Interrupt Controller

This block gathers up to 31 level-sensitive interrupt sources and presents them to one hart as a single external interrupt request. The request goes to both the machine-level and the supervisor-level external interrupt inputs. Each source has a pending bit that is a registered copy of its input level. An in-service mask records which sources software has taken and not yet finished.

Software reads the claim register to take the next source. The block returns the lowest-numbered source that is pending and not in service, and marks that source as in service. Software writes the same number back to the claim register when the handler is done. There are no priority levels, enables or thresholds, and arbitration always favours the lowest source number.

The register window is 4 MiB and accepts only 32-bit accesses. Only the claim register has any effect. A bus access starts on the first cycle that `bus_req` is high and lasts as long as it stays high. Read data is registered and valid from the cycle after the access starts.

Top module: `irq_claim_ctrl`

## Requirements
- R1: Source n (1..31) is carried on `src_level` bit n-1, and its pending bit equals that input level as sampled at the previous clock edge.
- R2: `irq_m_ext` and `irq_s_ext` are both high exactly when some source is pending and not in service. They reflect the masks as they stand after each clock edge.
- R3: A 32-bit read at byte offset 0x200004 returns the lowest eligible source number (bit index plus one) and marks that source as in service. When only that source was eligible, the outputs fall in the clock after the claim.
- R4: A claim read with no eligible source returns 0 and leaves the in-service mask unchanged.
- R5: A 32-bit write of value v at offset 0x200004 clears in-service bit v-1 when v-1 (modulo 2^32) is below 31. Any other v, including 0, has no effect.
- R6: A read at offset 0x200000, or at any offset other than 0x200004, returns 0 and changes no state. Writes to those offsets are ignored.
- R7: Only accesses with `bus_size` equal to 2 (a 4-byte access, size given as log2 of bytes) are accepted. Any other size reads as 0 and has no side effect.
- R8: A request held high across several cycles is a single access, so its claim or complete takes effect only once.
- R9: After reset, both masks are clear, `bus_rdata` is 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | 31 | Source input levels; bit n-1 carries source n |
| bus_req | input | 1 | Access request; a rising level starts one access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 22 | Byte offset within the register window |
| bus_size | input | 2 | Access size as log2 of bytes; only 2 is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid from the cycle after the access starts |
| irq_m_ext | output | 1 | Machine-level external interrupt request |
| irq_s_ext | output | 1 | Supervisor-level external interrupt request |

## Verification
Several source patterns are claimed in sequence: two scattered sources, the lowest source on its own, and the highest source on its own. The first pattern shows that arbitration favours the lower index. The two single-source patterns expose any off-by-one error in the bit-to-number mapping at either end of the range.

Completions are tried with a valid number, with zero, with a number past the last source, at the wrong offset and with the wrong size. The bench then claims again, so any stray clear of an in-service bit shows up in the returned value. Finally, a claim held over three cycles is followed by a second claim, which tells one claim per access apart from one claim per cycle.

// File: rtl/irq_claim_pkg.sv
package irq_claim_pkg;
  localparam int unsigned BUS_DATA_W   = 32;
  localparam int unsigned WIN_ADDR_W   = 22;
  localparam logic [1:0]  SIZE_WORD    = 2'd2;
  localparam logic [WIN_ADDR_W-1:0] CLAIM_OFFSET = 22'h200004;

  typedef enum logic [1:0] {
    ACC_NONE     = 2'd0,
    ACC_CLAIM    = 2'd1,
    ACC_COMPLETE = 2'd2,
    ACC_OTHER_RD = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned NSRC = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_level,
  output logic [NSRC-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= src_level;
  end

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pend_q == $past(src_level)); // R1
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int unsigned NSRC  = 31,
  parameter int unsigned IDX_W = 5
) (
  input  logic [NSRC-1:0]  elig,
  output logic [NSRC-1:0]  grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any
);
  logic [NSRC:0] lower_seen;
  assign lower_seen[0] = 1'b0;

  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    assign lower_seen[g+1] = lower_seen[g] | elig[g];
    assign grant[g]        = elig[g] & ~lower_seen[g];
  end

  assign any = lower_seen[NSRC];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) grant_idx = grant_idx | IDX_W'(i);
    end
  end

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant)); // R3
    AST_GRANT_SUBSET: assert ((grant & ~elig) == '0); // R3
  end
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_claim_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_req,
  input  logic                  bus_wr,
  input  logic [WIN_ADDR_W-1:0] bus_addr,
  input  logic [1:0]            bus_size,
  output acc_kind_e             acc_kind
);
  logic req_q;
  logic start;

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= bus_req;
  end

  assign start = bus_req & ~req_q;

  always_comb begin
    acc_kind = ACC_NONE;
    if (start) begin
      if (bus_size == SIZE_WORD && bus_addr == CLAIM_OFFSET)
        acc_kind = bus_wr ? ACC_COMPLETE : ACC_CLAIM;
      else if (!bus_wr)
        acc_kind = ACC_OTHER_RD;
    end
  end

  AST_HELD_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (bus_req && req_q) |-> acc_kind == ACC_NONE); // R8
endmodule

// File: rtl/irq_svc_mask.sv
module irq_svc_mask #(
  parameter int unsigned NSRC   = 31,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_claim,
  input  logic [NSRC-1:0]   grant,
  input  logic              do_complete,
  input  logic [DATA_W-1:0] cmpl_val,
  output logic [NSRC-1:0]   insvc_q
);
  logic [DATA_W-1:0] cmpl_idx;
  logic [NSRC-1:0]   clr_mask;

  assign cmpl_idx = cmpl_val - DATA_W'(1);

  always_comb begin
    clr_mask = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (do_complete && cmpl_idx == DATA_W'(i)) clr_mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           insvc_q <= '0;
    else if (do_claim) insvc_q <= insvc_q | grant;
    else               insvc_q <= insvc_q & ~clr_mask;
  end

  AST_CLAIM_ADDS_ONE: assert property (@(posedge clk) disable iff (rst)
    (do_claim && grant != '0) |=> $countones(insvc_q) == $past($countones(insvc_q)) + 1); // R3
  AST_COMPLETE_NEVER_SETS: assert property (@(posedge clk) disable iff (rst)
    do_complete |=> (insvc_q & ~$past(insvc_q)) == '0); // R5
endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
  import irq_claim_pkg::*;
#(
  parameter int unsigned NSRC = 31
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       src_level,
  input  logic                  bus_req,
  input  logic                  bus_wr,
  input  logic [WIN_ADDR_W-1:0] bus_addr,
  input  logic [1:0]            bus_size,
  input  logic [BUS_DATA_W-1:0] bus_wdata,
  output logic [BUS_DATA_W-1:0] bus_rdata,
  output logic                  irq_m_ext,
  output logic                  irq_s_ext
);
  localparam int unsigned IDX_W = $clog2(NSRC + 1);

  logic [NSRC-1:0]  pend_q;
  logic [NSRC-1:0]  insvc_q;
  logic [NSRC-1:0]  elig;
  logic [NSRC-1:0]  grant;
  logic [IDX_W-1:0] grant_idx;
  logic             any_elig;
  acc_kind_e        acc_kind;
  logic             do_claim;
  logic             do_complete;
  logic             irq_req;

  irq_pend_reg #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .src_level(src_level), .pend_q(pend_q)
  );

  assign elig = pend_q & ~insvc_q;

  irq_lowest_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .grant(grant), .grant_idx(grant_idx), .any(any_elig)
  );

  irq_bus_decode u_dec (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_size(bus_size), .acc_kind(acc_kind)
  );

  assign do_claim    = (acc_kind == ACC_CLAIM);
  assign do_complete = (acc_kind == ACC_COMPLETE);

  irq_svc_mask #(.NSRC(NSRC), .DATA_W(BUS_DATA_W)) u_svc (
    .clk(clk), .rst(rst), .do_claim(do_claim), .grant(grant),
    .do_complete(do_complete), .cmpl_val(bus_wdata), .insvc_q(insvc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (do_claim) begin
      bus_rdata <= any_elig ? BUS_DATA_W'(grant_idx) + BUS_DATA_W'(1) : '0;
    end else if (acc_kind == ACC_OTHER_RD) begin
      bus_rdata <= '0;
    end
  end

  assign irq_req   = any_elig;
  assign irq_m_ext = irq_req;
  assign irq_s_ext = irq_req;

  AST_EMPTY_CLAIM_STABLE: assert property (@(posedge clk) disable iff (rst)
    (do_claim && elig == '0) |=> $stable(insvc_q)); // R4
  AST_EMPTY_CLAIM_ZERO: assert property (@(posedge clk) disable iff (rst)
    (do_claim && elig == '0) |=> bus_rdata == '0); // R4
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_OTHER_RD) |=> bus_rdata == '0 && $stable(insvc_q)); // R6
  AST_BAD_SIZE_INERT: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_size != SIZE_WORD) |=> $stable(insvc_q)); // R7
  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (bus_req && $past(bus_req) && !$past(rst)) |=> $stable(insvc_q)); // R8
  AST_CLAIM_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (do_claim && $countones(elig) == 1 && src_level == pend_q) |=> !irq_m_ext); // R3
endmodule

// File: tb/irq_claim_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_claim_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [30:0] src_level;
  logic        bus_req;
  logic        bus_wr;
  logic [21:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_m_ext;
  logic        irq_s_ext;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  localparam logic [21:0] CLM = 22'h200004;

  always #2 clk = ~clk;

  irq_claim_ctrl dut_i (
    .clk(clk), .rst(rst), .src_level(src_level), .bus_req(bus_req),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_m_ext(irq_m_ext), .irq_s_ext(irq_s_ext)
  );

  // monitor: pops expected read data and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== 32'(e)) begin
        errors++;
        $display("FAIL %s rdata actual %0d expected %0d", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_op(input logic wr, input logic [21:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input int hold, input int e,
                        input string t);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    @(posedge clk);
    #1;
    if (!wr) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    for (int k = 1; k < hold; k++) @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic claim(input int e, input string t);
    bus_op(1'b0, CLM, 2'd2, 32'd0, 1, e, t);
  endtask

  task automatic complete(input int v);
    bus_op(1'b1, CLM, 2'd2, 32'(v), 1, 0, "");
  endtask

  task automatic set_src(input logic [30:0] v);
    @(negedge clk);
    src_level = v;
    @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    #1;
    checks++;
    if (irq_m_ext !== e || irq_s_ext !== e) begin
      errors++;
      $display("FAIL %s irq actual m=%0b s=%0b expected %0b", t, irq_m_ext, irq_s_ext, e);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; src_level = '0; bus_req = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_size = 2'd2; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check_irq(1'b0, "R9");
    checks++;
    if (bus_rdata !== 32'd0) begin
      errors++;
      $display("FAIL R9 rdata actual %0d expected 0", bus_rdata);
    end

    // R1/R2: sources 5 and 9 -> bits 4 and 8
    set_src(31'h0000_0110);
    check_irq(1'b1, "R2");
    claim(5, "R3");
    check_irq(1'b1, "R2");
    claim(9, "R3");
    check_irq(1'b0, "R2");
    claim(0, "R4");
    complete(5);
    check_irq(1'b1, "R5");
    claim(5, "R5");
    complete(0);          // R5: wraps, ignored
    complete(40);         // R5: out of range, ignored
    claim(0, "R5");
    // R6: wrong offset completion ignored; 0x200000 reads zero
    bus_op(1'b1, 22'h000004, 2'd2, 32'd9, 1, 0, "");
    bus_op(1'b1, 22'h200000, 2'd2, 32'd9, 1, 0, "");
    claim(0, "R6");
    complete(9);
    check_irq(1'b1, "R6");
    bus_op(1'b0, 22'h200000, 2'd2, 0, 1, 0, "R6");
    bus_op(1'b0, 22'h000010, 2'd2, 0, 1, 0, "R6");
    check_irq(1'b1, "R6");
    // R7: wrong sizes
    bus_op(1'b0, CLM, 2'd1, 0, 1, 0, "R7");
    check_irq(1'b1, "R7");
    claim(9, "R7");
    bus_op(1'b1, CLM, 2'd0, 32'd9, 1, 0, "");
    claim(0, "R7");
    complete(5);
    complete(9);
    set_src(31'h0);
    check_irq(1'b0, "R1");

    // R1 mapping at both ends
    set_src(31'h0000_0001);
    claim(1, "R1");
    complete(1);
    set_src(31'h4000_0000);
    claim(31, "R1");
    check_irq(1'b0, "R3");
    complete(31);
    check_irq(1'b1, "R5");
    claim(31, "R5");
    complete(31);
    set_src(31'h0);

    // R8: held claim acts once
    set_src(31'h0000_0006);
    bus_op(1'b0, CLM, 2'd2, 0, 3, 2, "R8");
    check_irq(1'b1, "R8");
    claim(3, "R8");
    check_irq(1'b0, "R8");
    complete(2);
    complete(3);
    set_src(31'h0);
    check_irq(1'b0, "R1");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule